// File: doc/BRIEF.md
# Address-masked GPIO data port

This block is the data register path of a small GPIO port. Every access to its 256-word data window carries a per-pin mask in the address. A write changes only the output latch bits selected by the mask. A read returns only the selected pins. Because of this, setting, clearing or loading any subset of pins takes one bus transaction and needs no read-modify-write sequence. An all-ones address reaches the whole port.

The bus side receives the word address, which is byte address bits [9:2], so bit i of `addr_i` selects pin i. A read is answered one cycle after its request with `rvalid_o`.

- For output pins (direction bit 1), a read returns the latch value.
- For input pins, a read returns the pad value after it has passed a two-flop synchronizer.

Inverting a pin subset is not atomic. Software reads the pins, then writes the inverted value back under a mask.

Top module: `gpio_masked_port`

## Requirements
- R1: After reset, `out_o` is 0, `rvalid_o` is 0 and `rdata_o` is 0.
- R2: A write (`req_i`=1, `we_i`=1) loads `wdata_i[i]` into latch bit i for every pin i where `addr_i[i]`=1. The new value appears on `out_o` one cycle after the request.
- R3: On a write, latch bits whose `addr_i` bit is 0 keep their value whatever `wdata_i` holds. Without a write the latch does not change.
- R4: Each read request (`req_i`=1, `we_i`=0) gives `rvalid_o`=1 in the following cycle. In that cycle, `rdata_o` bits of pins with mask bit 0 are 0, and bits at NUM_PINS and above are 0. When there is no read request, `rvalid_o` is 0 in the following cycle.
- R5: For a read of a pin whose `dir_i` bit is 1, `rdata_o` returns that pin's latch value.
- R6: For a read of a pin whose `dir_i` bit is 0, `rdata_o` returns the pad through two flops. A pad level first sampled at clock edge n is returned by read requests sampled at edge n+2 or later. Requests sampled at edges n and n+1 still return the earlier level.
- R7: An address of all ones reads or writes every pin.
- R8: Reading the pins and then writing back the inverted value under a mask toggles exactly the masked output pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | NUM_PINS | Word address (byte address bits [9:2]) and pin mask |
| wdata_i | input | NUM_PINS | Write data, one bit per pin |
| rdata_o | output | DATA_W | Read data, zero-extended |
| rvalid_o | output | 1 | Read data valid |
| dir_i | input | NUM_PINS | Per-pin direction, 1 = output |
| pad_i | input | NUM_PINS | Asynchronous pad levels |
| out_o | output | NUM_PINS | Output latch |

## Verification
The hardest case to reach from the ports is the synchronizer latency boundary. The bench needs back-to-back reads that straddle a pad change, so that the two reads before the third edge see the old level and the next read sees the new one. To get there, the pad changes in the same half cycle that a full-mask read request is raised. The request is then held for three cycles and each response is compared against the old or new level. The bench also sweeps every one of the 256 masks for writes, and for reads under several direction patterns.

// File: rtl/gpio_mport_pkg.sv
package gpio_mport_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;
endpackage

// File: rtl/gpio_mport_sync.sv
module gpio_mport_sync #(
  parameter int NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pad_i,
  output logic [NUM_PINS-1:0] sync_o
);
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= pad_i[g];
        s2_q <= s1_q;
      end
    end
    assign sync_o[g] = s2_q;
  end
endmodule

// File: rtl/gpio_mport_latch.sv
module gpio_mport_latch #(
  parameter int NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [NUM_PINS-1:0] mask_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else if (wr_en_i) q_o <= (q_o & ~mask_i) | (wdata_i & mask_i);
  end

  // R2
  masked_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ((q_o ^ $past(wdata_i)) & $past(mask_i)) == '0);
  // R3
  keep_unmasked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ((q_o ^ $past(q_o)) & ~$past(mask_i)) == '0);
  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(q_o));
endmodule

// File: rtl/gpio_mport_rd.sv
module gpio_mport_rd #(
  parameter int NUM_PINS = 8,
  parameter int DATA_W   = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rd_en_i,
  input  logic [NUM_PINS-1:0] mask_i,
  input  logic [NUM_PINS-1:0] dir_i,
  input  logic [NUM_PINS-1:0] latch_i,
  input  logic [NUM_PINS-1:0] sync_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                rvalid_o
);
  logic [NUM_PINS-1:0] pin_val;
  assign pin_val = ((dir_i & latch_i) | (~dir_i & sync_i)) & mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_en_i;
      rdata_o  <= rd_en_i ? DATA_W'(pin_val) : '0;
    end
  end

  // R4
  rvalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rvalid_o);
  // R4
  no_rvalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rvalid_o);
  // R4
  unmasked_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> (rdata_o[NUM_PINS-1:0] & ~$past(mask_i)) == '0);
  // R5
  out_pin_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> ((rdata_o[NUM_PINS-1:0] ^ $past(latch_i)) & $past(mask_i & dir_i)) == '0);

  if (DATA_W > NUM_PINS) begin : g_hi
    // R4
    upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rvalid_o |-> rdata_o[DATA_W-1:NUM_PINS] == '0);
  end
endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port #(
  parameter int NUM_PINS = 8,
  parameter int DATA_W   = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [NUM_PINS-1:0] addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                rvalid_o,
  input  logic [NUM_PINS-1:0] dir_i,
  input  logic [NUM_PINS-1:0] pad_i,
  output logic [NUM_PINS-1:0] out_o
);
  import gpio_mport_pkg::*;

  acc_e                acc;
  logic [NUM_PINS-1:0] sync_val;

  always_comb begin
    if (!req_i)    acc = ACC_IDLE;
    else if (we_i) acc = ACC_WRITE;
    else           acc = ACC_READ;
  end

  gpio_mport_sync #(.NUM_PINS(NUM_PINS)) sync_i (
    .clk_i, .rst_ni, .pad_i, .sync_o(sync_val)
  );

  gpio_mport_latch #(.NUM_PINS(NUM_PINS)) latch_i (
    .clk_i, .rst_ni,
    .wr_en_i(acc == ACC_WRITE),
    .mask_i (addr_i),
    .wdata_i,
    .q_o    (out_o)
  );

  gpio_mport_rd #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) rd_i (
    .clk_i, .rst_ni,
    .rd_en_i(acc == ACC_READ),
    .mask_i (addr_i),
    .dir_i,
    .latch_i(out_o),
    .sync_i (sync_val),
    .rdata_o,
    .rvalid_o
  );
endmodule

// File: tb/gpio_masked_port_tb_top.sv
module gpio_masked_port_tb_top;
  localparam int NP = 8;
  localparam int DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [NP-1:0] addr = '0, wdata = '0, dir = '0, pad = '0;
  logic [DW-1:0] rdata;
  logic rvalid;
  logic [NP-1:0] out;

  int n_run = 0, n_fail = 0;
  logic [NP-1:0] lat_m = '0;

  always #2.5 clk = ~clk;

  gpio_masked_port #(.NUM_PINS(NP), .DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .dir_i(dir),
    .pad_i(pad), .out_o(out)
  );

  task automatic chk(input bit ok, input string rq, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic do_write(input logic [NP-1:0] m, input logic [NP-1:0] d,
                          input string rq);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = m; wdata = d;
    lat_m = (lat_m & ~m) | (d & m);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    chk(out == lat_m, rq, DW'(out), DW'(lat_m));
  endtask

  task automatic do_read(input logic [NP-1:0] m, output logic [DW-1:0] r);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = m;
    @(negedge clk);
    req = 1'b0;
    chk(rvalid == 1'b1, "R4 rvalid", DW'(rvalid), 1);
    r = rdata;
  endtask

  initial begin
    #(5.0 * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] r;
    logic [NP-1:0] e;
    logic [NP-1:0] dirs [4];
    logic [NP-1:0] pads [4];
    dirs[0] = 8'h00; dirs[1] = 8'hFF; dirs[2] = 8'hA5; dirs[3] = 8'h3C;
    pads[0] = 8'h5A; pads[1] = 8'hC3; pads[2] = 8'h0F; pads[3] = 8'h96;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(out == '0, "R1 out", DW'(out), 0);
    chk(rvalid == 1'b0, "R1 rvalid", DW'(rvalid), 0);
    chk(rdata == '0, "R1 rdata", rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rvalid == 1'b0, "R4 idle no rvalid", DW'(rvalid), 0);

    // R7 full-port write
    do_write(8'hFF, 8'hA6, "R7 full write");
    // R3 zero mask ignores data
    do_write(8'h00, 8'h59, "R3 zero mask");
    // R2/R3 sweep of all masks
    for (int m = 0; m < 256; m++) begin
      do_write(NP'(m), NP'(m * 29 + 7), "R2 R3 mask sweep");
    end

    // R5/R6/R4 read sweep
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      dir = dirs[k]; pad = pads[k];
      repeat (3) @(negedge clk);
      for (int m = 0; m < 256; m++) begin
        do_read(NP'(m), r);
        e = ((dir & lat_m) | (~dir & pad)) & NP'(m);
        chk(r == DW'(e), "R4 R5 R6 read sweep", r, DW'(e));
        chk(out == lat_m, "R3 read leaves latch", DW'(out), DW'(lat_m));
      end
    end

    // R6 synchronizer latency: reads at edges n, n+1 old; n+2 new
    @(negedge clk);
    dir = 8'h00; pad = 8'h00;
    repeat (3) @(negedge clk);
    pad = 8'hE7; req = 1'b1; we = 1'b0; addr = 8'hFF;
    @(negedge clk);
    chk(rdata == 32'h0, "R6 edge n old", rdata, 0);
    @(negedge clk);
    chk(rdata == 32'h0, "R6 edge n+1 old", rdata, 0);
    @(negedge clk);
    chk(rdata == 32'hE7, "R6 edge n+2 new", rdata, 32'hE7);
    req = 1'b0;
    @(negedge clk);
    chk(rvalid == 1'b0, "R4 rvalid drops", DW'(rvalid), 0);

    // R8 toggle via read then masked write
    @(negedge clk);
    dir = 8'hFF;
    for (int m = 1; m < 256; m += 17) begin
      e = lat_m;
      do_read(8'hFF, r);
      chk(r == DW'(e), "R7 full read", r, DW'(e));
      do_write(NP'(m), ~r[NP-1:0], "R8 toggle write");
      chk(out == (e ^ NP'(m)), "R8 toggle", DW'(out), DW'(e ^ NP'(m)));
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule